// File: doc/BRIEF.md
# Transactional Cache Speculative State Tracker

This block keeps the speculative bookkeeping for a small direct-mapped data cache that runs code as transactions. For every line it records which words the running transaction has read and which it has fully overwritten (renamed), plus one modified flag per line. Stores stay local to the node until commit, so other nodes never see them early. Meanwhile the block watches the addresses of writes that other nodes have committed and broadcast. If one of those addresses lands on a word this transaction read before writing it, the block raises a rollback request.

A word that the transaction fully overwrote before reading it carries no dependence on outside writes. Reads of such a word leave no read mark. A commit pulse makes the transaction's modified lines committed-dirty and drops all speculative marks. An abort pulse drops the marks too, and it invalidates every line the transaction modified. The cache holds 16 lines of 4 words by default. A word address splits into word offset (low bits), line index (next bits) and tag (the rest).

Top module: `txn_spec_tracker`

## Requirements
- R1: After reset `violation` is 0 and `line_valid`, `line_mod` and `line_dirty` are all zero.
- R2: A local access (`acc_valid`=1) makes the indexed line valid from the next cycle with the access tag, and any store (`acc_kind` not 0) sets that line's `line_mod` bit.
- R3: A load (`acc_kind`=0) of a word that was not fully overwritten marks the word as read. A snoop in a later cycle whose tag, index and word offset all match it sets `violation` at the next clock edge. `violation` then stays 1 until a commit or abort.
- R4: A snoop that differs from every read word in tag, line index or word offset leaves `violation` at 0.
- R5: A whole-word store (`acc_kind` bit 1 set) renames the word. A later load of that word leaves no read mark, so a snoop of it does not set `violation`.
- R6: A partial store (`acc_kind`=1) does not rename. A later load of that word marks it read, and a matching snoop sets `violation`.
- R7: A load followed by a whole-word store of the same word keeps the read mark, and a matching snoop still sets `violation`.
- R8: A `commit` pulse clears `violation` and all read and rename marks. Each modified line keeps its valid bit, sets `line_dirty` and clears `line_mod`.
- R9: An `abort` pulse clears `violation`, all read and rename marks and `line_mod`, and clears `line_valid` of every modified line. Unmodified lines stay valid.
- R10: An access that misses on a valid line holding read marks or a set modified bit sets `violation` at the next edge. A miss on a line with no speculative state retags the line and does not set `violation`.
- R11: `abort` takes priority over `commit` and over a local access in the same cycle. Neither the commit nor the access has any effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Local load/store this cycle |
| acc_kind | input | 2 | 0 load, 1 partial store, 2 or 3 whole-word store |
| acc_addr | input | ADDR_W | Local word address {tag, index, word} |
| snp_valid | input | 1 | Committed remote write seen this cycle |
| snp_addr | input | ADDR_W | Snooped word address |
| commit | input | 1 | Transaction commit pulse |
| abort | input | 1 | Transaction abort pulse |
| violation | output | 1 | Rollback request, held until commit or abort |
| line_valid | output | LINES | Per-line valid |
| line_mod | output | LINES | Per-line speculatively modified |
| line_dirty | output | LINES | Per-line committed dirty |

## Verification
The hardest state to reach from the ports is a word that carries both a read mark and a rename mark, because only a read followed by a whole-word write creates it. The bench builds it by issuing the load and then the whole-word store to the same address before snooping. It also drives a line into a tag conflict while it holds speculative state, which needs two accesses with the same index and different tags inside one transaction. A cycle that raises abort, commit and a store together exercises the priority order. The bench checks the outcome on lines that the commit and the store alone would have changed.

// File: rtl/txn_pkg.sv
package txn_pkg;
   typedef enum logic [1:0] {
      ACC_LOAD      = 2'd0,
      ACC_STORE_PRT = 2'd1,
      ACC_STORE_WRD = 2'd2,
      ACC_STORE_WR2 = 2'd3
   } acc_kind_e;

   function automatic logic kind_is_store(input acc_kind_e k);
      return k != ACC_LOAD;
   endfunction

   function automatic logic kind_is_whole(input acc_kind_e k);
      return k[1];
   endfunction
endpackage

// File: rtl/txn_line.sv
module txn_line #(
   parameter int WORDS = 4,
   parameter int TAG_W = 10,
   localparam int WB = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_sel,
   input  logic             acc_write,
   input  logic             acc_full,
   input  logic [TAG_W-1:0] acc_tag,
   input  logic [WB-1:0]    acc_word,
   input  logic             snp_sel,
   input  logic [TAG_W-1:0] snp_tag,
   input  logic [WB-1:0]    snp_word,
   input  logic             commit,
   input  logic             abort,
   output logic             valid_o,
   output logic             mod_o,
   output logic             dirty_o,
   output logic             snp_hit_o,
   output logic             conflict_o
);
   logic             valid_q, mod_q, dirty_q;
   logic [TAG_W-1:0] tag_q;
   logic [WORDS-1:0] rd_q, rn_q;

   logic             valid_d, mod_d, dirty_d;
   logic [TAG_W-1:0] tag_d;
   logic [WORDS-1:0] rd_d, rn_d;
   logic             tag_hit, live;

   assign tag_hit    = valid_q && (tag_q == acc_tag);
   assign live       = (|rd_q) || mod_q;
   assign conflict_o = acc_sel && valid_q && (tag_q != acc_tag) && live;
   assign snp_hit_o  = snp_sel && valid_q && (tag_q == snp_tag) && rd_q[snp_word];

   always_comb begin
      valid_d = valid_q;
      mod_d   = mod_q;
      dirty_d = dirty_q;
      tag_d   = tag_q;
      rd_d    = rd_q;
      rn_d    = rn_q;
      if (abort) begin
         valid_d = valid_q && !mod_q;
         mod_d   = 1'b0;
         rd_d    = '0;
         rn_d    = '0;
      end else if (commit) begin
         dirty_d = dirty_q || mod_q;
         mod_d   = 1'b0;
         rd_d    = '0;
         rn_d    = '0;
      end else if (acc_sel) begin
         if (!tag_hit) begin
            mod_d   = 1'b0;
            dirty_d = 1'b0;
            rd_d    = '0;
            rn_d    = '0;
         end
         valid_d = 1'b1;
         tag_d   = acc_tag;
         if (acc_write) begin
            mod_d = 1'b1;
            if (acc_full) rn_d[acc_word] = 1'b1;
         end else if (!rn_d[acc_word]) begin
            rd_d[acc_word] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         mod_q   <= 1'b0;
         dirty_q <= 1'b0;
         tag_q   <= '0;
         rd_q    <= '0;
         rn_q    <= '0;
      end else begin
         valid_q <= valid_d;
         mod_q   <= mod_d;
         dirty_q <= dirty_d;
         tag_q   <= tag_d;
         rd_q    <= rd_d;
         rn_q    <= rn_d;
      end
   end

   assign valid_o = valid_q;
   assign mod_o   = mod_q;
   assign dirty_o = dirty_q;

   // R5
   rename_needs_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|rn_q) |-> (mod_q && valid_q));
   // R2
   access_validates_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_sel && !abort && !commit) |=> (valid_q && tag_q == $past(acc_tag)));
endmodule

// File: rtl/txn_viol.sv
module txn_viol #(
   parameter int LINES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] snp_hits,
   input  logic [LINES-1:0] conflicts,
   input  logic             commit,
   input  logic             abort,
   output logic             violation
);
   logic viol_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                viol_q <= 1'b0;
      else if (abort || commit)  viol_q <= 1'b0;
      else if ((|snp_hits) || (|conflicts)) viol_q <= 1'b1;
   end

   assign violation = viol_q;

   // R3
   viol_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(viol_q) |-> $past((|snp_hits) || (|conflicts)));
   // R3
   viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_q && !abort && !commit) |=> viol_q);
endmodule

// File: rtl/txn_spec_tracker.sv
module txn_spec_tracker #(
   parameter int LINES  = 16,
   parameter int WORDS  = 4,
   parameter int ADDR_W = 16,
   localparam int WB    = $clog2(WORDS),
   localparam int IB    = $clog2(LINES),
   localparam int TAG_W = ADDR_W - IB - WB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [1:0]        acc_kind,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              snp_valid,
   input  logic [ADDR_W-1:0] snp_addr,
   input  logic              commit,
   input  logic              abort,
   output logic              violation,
   output logic [LINES-1:0]  line_valid,
   output logic [LINES-1:0]  line_mod,
   output logic [LINES-1:0]  line_dirty
);
   import txn_pkg::*;

   if ((1 << WB) != WORDS || WORDS < 2) begin : g_bad_words
      $error("WORDS must be a power of two, at least 2");
   end
   if ((1 << IB) != LINES || LINES < 2) begin : g_bad_lines
      $error("LINES must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W too small for LINES and WORDS");
   end

   acc_kind_e        kind;
   logic             is_store, is_whole;
   logic [WB-1:0]    a_word, s_word;
   logic [IB-1:0]    a_idx, s_idx;
   logic [TAG_W-1:0] a_tag, s_tag;
   logic [LINES-1:0] hits, confl;

   assign kind     = acc_kind_e'(acc_kind);
   assign is_store = kind_is_store(kind);
   assign is_whole = kind_is_whole(kind);
   assign {a_tag, a_idx, a_word} = acc_addr;
   assign {s_tag, s_idx, s_word} = snp_addr;

   for (genvar i = 0; i < LINES; i++) begin : g_line
      txn_line #(.WORDS(WORDS), .TAG_W(TAG_W)) u_line (
         .clk       (clk),
         .rst_n     (rst_n),
         .acc_sel   (acc_valid && (a_idx == IB'(i))),
         .acc_write (is_store),
         .acc_full  (is_whole),
         .acc_tag   (a_tag),
         .acc_word  (a_word),
         .snp_sel   (snp_valid && (s_idx == IB'(i))),
         .snp_tag   (s_tag),
         .snp_word  (s_word),
         .commit    (commit),
         .abort     (abort),
         .valid_o   (line_valid[i]),
         .mod_o     (line_mod[i]),
         .dirty_o   (line_dirty[i]),
         .snp_hit_o (hits[i]),
         .conflict_o(confl[i])
      );
   end

   txn_viol #(.LINES(LINES)) u_viol (
      .clk      (clk),
      .rst_n    (rst_n),
      .snp_hits (hits),
      .conflicts(confl),
      .commit   (commit),
      .abort    (abort),
      .violation(violation)
   );

   // R9
   abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!violation && line_mod == '0
                 && (line_valid & $past(line_mod)) == '0));
   // R8
   commit_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !abort) |=> (!violation && line_mod == '0
                 && (line_dirty & $past(line_mod)) == $past(line_mod)));
   // R11
   abort_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> ((line_valid & ~$past(line_valid)) == '0));
endmodule

// File: tb/txn_spec_tracker_test.sv
module txn_spec_tracker_test;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_valid = 1'b0;
   logic [1:0]    acc_kind = 2'd0;
   logic [AW-1:0] acc_addr = '0;
   logic          snp_valid = 1'b0;
   logic [AW-1:0] snp_addr = '0;
   logic          commit = 1'b0;
   logic          abort = 1'b0;
   logic          violation;
   logic [15:0]   line_valid, line_mod, line_dirty;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   txn_spec_tracker uut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
      .acc_addr(acc_addr), .snp_valid(snp_valid), .snp_addr(snp_addr),
      .commit(commit), .abort(abort), .violation(violation),
      .line_valid(line_valid), .line_mod(line_mod), .line_dirty(line_dirty)
   );

   function automatic logic [AW-1:0] mk(input int tag, input int idx, input int w);
      return {tag[9:0], idx[3:0], w[1:0]};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic access(input int kind, input logic [AW-1:0] a);
      acc_valid = 1'b1; acc_kind = kind[1:0]; acc_addr = a;
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic snoop(input logic [AW-1:0] a);
      snp_valid = 1'b1; snp_addr = a;
      @(negedge clk);
      snp_valid = 1'b0;
   endtask

   task automatic do_commit();
      commit = 1'b1; @(negedge clk); commit = 1'b0;
   endtask

   task automatic do_abort();
      abort = 1'b1; @(negedge clk); abort = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 violation", violation, 0);
      chk("R1 valid", line_valid, 0);
      chk("R1 mod", line_mod, 0);
      chk("R1 dirty", line_dirty, 0);
   endtask

   task automatic t_read_snoop();
      access(0, mk(1, 2, 1));
      chk("R2 valid after load", line_valid[2], 1);
      chk("R2 load leaves mod", line_mod[2], 0);
      snoop(mk(1, 2, 1));
      chk("R3 snoop of read word", violation, 1);
      @(negedge clk);
      chk("R3 violation held", violation, 1);
      do_abort();
      chk("R9 abort clears violation", violation, 0);
      chk("R9 unmodified line stays valid", line_valid[2], 1);
   endtask

   task automatic t_no_match();
      access(0, mk(1, 3, 0));
      snoop(mk(1, 3, 1));
      chk("R4 other word", violation, 0);
      snoop(mk(2, 3, 0));
      chk("R4 other tag", violation, 0);
      snoop(mk(1, 4, 0));
      chk("R4 other line", violation, 0);
      do_commit();
   endtask

   task automatic t_rename();
      access(2, mk(3, 5, 2));
      chk("R2 store sets mod", line_mod[5], 1);
      access(0, mk(3, 5, 2));
      snoop(mk(3, 5, 2));
      chk("R5 renamed word not a dependence", violation, 0);
      do_abort();
      chk("R9 modified line invalid", line_valid[5], 0);
      chk("R9 mod cleared", line_mod[5], 0);
   endtask

   task automatic t_partial();
      access(1, mk(3, 6, 1));
      access(0, mk(3, 6, 1));
      snoop(mk(3, 6, 1));
      chk("R6 partial store then load", violation, 1);
      do_abort();
   endtask

   task automatic t_read_then_write();
      access(0, mk(4, 7, 0));
      access(3, mk(4, 7, 0));
      snoop(mk(4, 7, 0));
      chk("R7 read mark kept", violation, 1);
      do_abort();
   endtask

   task automatic t_commit();
      access(0, mk(5, 8, 3));
      access(2, mk(5, 9, 0));
      do_commit();
      chk("R8 dirty after commit", line_dirty[9], 1);
      chk("R8 mod cleared", line_mod[9], 0);
      chk("R8 stays valid", line_valid[9], 1);
      snoop(mk(5, 8, 3));
      chk("R8 read marks cleared", violation, 0);
      access(0, mk(5, 8, 3));
      snoop(mk(5, 8, 3));
      chk("R3 violation before commit", violation, 1);
      do_commit();
      chk("R8 commit clears violation", violation, 0);
   endtask

   task automatic t_conflict();
      access(0, mk(6, 10, 0));
      access(0, mk(7, 10, 0));
      chk("R10 conflict on live line", violation, 1);
      do_abort();
      access(0, mk(6, 11, 0));
      do_commit();
      access(0, mk(7, 11, 0));
      chk("R10 clean miss no violation", violation, 0);
      snoop(mk(6, 11, 0));
      chk("R10 old tag gone", violation, 0);
      snoop(mk(7, 11, 0));
      chk("R10 retagged line tracks reads", violation, 1);
      do_abort();
   endtask

   task automatic t_priority();
      access(0, mk(8, 12, 0));
      access(2, mk(8, 13, 0));
      abort = 1'b1; commit = 1'b1;
      acc_valid = 1'b1; acc_kind = 2'd2; acc_addr = mk(8, 14, 0);
      @(negedge clk);
      abort = 1'b0; commit = 1'b0; acc_valid = 1'b0;
      chk("R11 abort beats commit valid", line_valid[13], 0);
      chk("R11 abort beats commit dirty", line_dirty[13], 0);
      chk("R11 access ignored", line_valid[14], 0);
      chk("R11 access mod ignored", line_mod[14], 0);
      snoop(mk(8, 12, 0));
      chk("R11 read marks cleared", violation, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_read_snoop();
      t_no_match();
      t_rename();
      t_partial();
      t_read_then_write();
      t_commit();
      t_conflict();
      t_priority();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule